// File: doc/BRIEF.md
# Lookup RAM Transfer Sequencer with Result Forwarding

This block moves single words between a processor core's register file and a private lookup RAM that it owns. A read command copies one lookup word into a register-file destination. A write command stores a register value into a lookup location. The block contains the RAM and drives its address, write data and write enable, which are also visible at the ports. It answers the instruction sequencer with a busy level and a one-cycle done pulse.

A read occupies three busy cycles. In the first it presents the address. In the second it registers the RAM output into a hold register. In the third it drives the register-file write port from that hold register. A write occupies two busy cycles: the store is issued in the first and done is signalled in the second.

Once a read reaches its final cycle, the read's data and destination stay in the block. A forwarding stage compares every source-operand address of the following instruction with the held destination. On a match it substitutes the held word for the value coming out of the register file. The held value stays live until the next command is accepted.

Top module: `lut_xfer_seq`

## Requirements
- R1: After reset, busy, done, lut_we and rf_we are all 0, and every src_data lane equals its src_rdata lane.
- R2: A read accepted at a clock edge (cmd_valid=1, cmd_write=0, busy=0) keeps busy at 1 for exactly the next three cycles. Done is 1 only in the third of them, and in that cycle rf_we=1, rf_waddr is the command's cmd_rf_addr and rf_wdata is the lookup word at cmd_lut_addr.
- R3: A write accepted at a clock edge (cmd_write=1) keeps busy at 1 for exactly two cycles. In the first, lut_we=1, lut_addr=cmd_lut_addr and lut_wdata=cmd_wdata. In the second, lut_we=0 and done=1.
- R4: cmd_valid is ignored while busy=1. Such a command starts no operation, changes no RAM word and does not lengthen the busy period.
- R5: From the final cycle of a read until the next command is accepted, any source lane whose address equals the read's destination outputs the read data on src_data.
- R6: A source lane whose address does not match, or that sees no held read, passes src_rdata through unchanged.
- R7: A read of a lookup address that immediately follows a write to the same address returns the newly written data.
- R8: rf_we is 1 only in the final cycle of a read and never during a write.
- R9: Done lasts one cycle and busy is 0 in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken only when busy is 0 |
| cmd_write | input | 1 | 1 = store to lookup RAM, 0 = load from lookup RAM |
| cmd_lut_addr | input | LUT_AW (9) | Lookup RAM word address |
| cmd_rf_addr | input | RF_AW (9) | Register-file destination of a read |
| cmd_wdata | input | DW (32) | Register value to store on a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| lut_addr | output | LUT_AW (9) | Address presented to the lookup RAM |
| lut_wdata | output | DW (32) | Data presented to the lookup RAM |
| lut_we | output | 1 | Lookup RAM write enable |
| rf_we | output | 1 | Register-file write enable for a read result |
| rf_waddr | output | RF_AW (9) | Register-file write address |
| rf_wdata | output | DW (32) | Register-file write data |
| src_addr | input | NUM_SRC*RF_AW (18) | Source-operand addresses, lane 0 in the low bits |
| src_rdata | input | NUM_SRC*DW (64) | Register-file values for those sources |
| src_data | output | NUM_SRC*DW (64) | Operand values after forwarding |

## Verification
A wrong sequencer state shows at once as a busy period of the wrong length or a misplaced done pulse, because each state maps directly to busy, done, lut_we and rf_we in the same cycle. A corrupted hold register or held destination appears on rf_wdata in the read's final cycle. It also appears on the forwarded lanes in that cycle and in the idle cycle after it. A write landing at the wrong place, or a command leaking in while busy, only shows when that RAM word is read back later. The mixed random sequence therefore reads back recently written addresses often.

// File: rtl/lut_seq_pkg.sv
// Package: shared types for the lookup transfer sequencer.
// Assumes one command in flight at a time.
package lut_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_CAPT  = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/lut_seq_ram.sv
// Module: single-port lookup RAM with one cycle of read latency.
// Assumes read-before-write on a same-address access; contents carry no reset.
module lut_seq_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mem [DEPTH];

    // Store on write enable and register the addressed word every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        q <= mem[addr];
    end
endmodule

// File: rtl/lut_seq_fsm.sv
// Module: sequences a lookup read (issue, capture, finish) or a write (issue, finish).
// Keeps the read result and destination for forwarding until the next accept.
// Assumes the RAM output is valid one cycle after the address is presented.
module lut_seq_fsm
    import lut_seq_pkg::*;
#(
    parameter int LUT_AW = 9,
    parameter int RF_AW  = 9,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [LUT_AW-1:0] cmd_lut_addr,
    input  logic [RF_AW-1:0]  cmd_rf_addr,
    input  logic [DW-1:0]     cmd_wdata,
    input  logic [DW-1:0]     ram_q,
    output logic              busy,
    output logic              done,
    output logic [LUT_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic              ram_we,
    output logic              rf_we,
    output logic [RF_AW-1:0]  rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              fwd_live,
    output logic [RF_AW-1:0]  fwd_addr,
    output logic [DW-1:0]     fwd_data
);
    seq_state_t        state, state_nx;
    logic              op_wr;
    logic [LUT_AW-1:0] lut_addr_q;
    logic [RF_AW-1:0]  rf_addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     hold_data;
    logic              hold_valid;
    logic              accept;

    assign accept = (state == ST_IDLE) && cmd_valid;

    // Next-state selection for the transfer sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = op_wr ? ST_FIN : ST_CAPT;
            ST_CAPT:  state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Command capture on acceptance only, so commands seen while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr      <= 1'b0;
            lut_addr_q <= '0;
            rf_addr_q  <= '0;
            wdata_q    <= '0;
        end else if (accept) begin
            op_wr      <= cmd_write;
            lut_addr_q <= cmd_lut_addr;
            rf_addr_q  <= cmd_rf_addr;
            wdata_q    <= cmd_wdata;
        end
    end

    // Hold register: loaded from the RAM output in the capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_data <= '0;
        else if (state == ST_CAPT)   hold_data <= ram_q;
    end

    // Held-result validity: set after a read finishes, dropped at the next accept.
    always_ff @(posedge clk) begin
        if (!rst_n)                              hold_valid <= 1'b0;
        else if (accept)                         hold_valid <= 1'b0;
        else if (state == ST_FIN && !op_wr)      hold_valid <= 1'b1;
    end

    // Output decode from the current state.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        ram_addr  = lut_addr_q;
        ram_wdata = wdata_q;
        ram_we    = (state == ST_ISSUE) && op_wr;
        rf_we     = (state == ST_FIN) && !op_wr;
        rf_waddr  = rf_addr_q;
        rf_wdata  = hold_data;
        fwd_live  = rf_we || hold_valid;
        fwd_addr  = rf_addr_q;
        fwd_data  = hold_data;
    end
endmodule

// File: rtl/lut_seq_fwd.sv
// Module: per-lane operand forwarding; a lane matching the held destination
// takes the held read data, otherwise the register-file value.
// Assumes lanes are packed with lane 0 in the low bits.
module lut_seq_fwd #(
    parameter int NUM_SRC = 2,
    parameter int RF_AW   = 9,
    parameter int DW      = 32
) (
    input  logic                   fwd_live,
    input  logic [RF_AW-1:0]       fwd_addr,
    input  logic [DW-1:0]          fwd_data,
    input  logic [NUM_SRC*RF_AW-1:0] src_addr,
    input  logic [NUM_SRC*DW-1:0]  src_rdata,
    output logic [NUM_SRC*DW-1:0]  src_data
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
        logic hit;
        // Compare this lane's address with the held destination.
        assign hit = fwd_live && (src_addr[g*RF_AW +: RF_AW] == fwd_addr);
        // Select the held word or the register-file word.
        assign src_data[g*DW +: DW] = hit ? fwd_data : src_rdata[g*DW +: DW];
    end
endmodule

// File: rtl/lut_xfer_seq.sv
// Module: top of the lookup transfer sequencer; joins the sequencer, the
// lookup RAM and the forwarding lanes. Assumes the caller waits for busy low.
module lut_xfer_seq #(
    parameter int LUT_DEPTH = 512,
    parameter int RF_AW     = 9,
    parameter int DW        = 32,
    parameter int NUM_SRC   = 2,
    localparam int LUT_AW   = $clog2(LUT_DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic                     cmd_write,
    input  logic [LUT_AW-1:0]        cmd_lut_addr,
    input  logic [RF_AW-1:0]         cmd_rf_addr,
    input  logic [DW-1:0]            cmd_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [LUT_AW-1:0]        lut_addr,
    output logic [DW-1:0]            lut_wdata,
    output logic                     lut_we,
    output logic                     rf_we,
    output logic [RF_AW-1:0]         rf_waddr,
    output logic [DW-1:0]            rf_wdata,
    input  logic [NUM_SRC*RF_AW-1:0] src_addr,
    input  logic [NUM_SRC*DW-1:0]    src_rdata,
    output logic [NUM_SRC*DW-1:0]    src_data
);
    logic [DW-1:0]    ram_q;
    logic             fwd_live;
    logic [RF_AW-1:0] fwd_addr;
    logic [DW-1:0]    fwd_data;

    lut_seq_fsm #(.LUT_AW(LUT_AW), .RF_AW(RF_AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_lut_addr(cmd_lut_addr), .cmd_rf_addr(cmd_rf_addr), .cmd_wdata(cmd_wdata),
        .ram_q(ram_q),
        .busy(busy), .done(done),
        .ram_addr(lut_addr), .ram_wdata(lut_wdata), .ram_we(lut_we),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .fwd_live(fwd_live), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
    );

    lut_seq_ram #(.DEPTH(LUT_DEPTH), .DW(DW)) u_ram (
        .clk(clk), .we(lut_we), .addr(lut_addr), .wdata(lut_wdata), .q(ram_q)
    );

    lut_seq_fwd #(.NUM_SRC(NUM_SRC), .RF_AW(RF_AW), .DW(DW)) u_fwd (
        .fwd_live(fwd_live), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
        .src_addr(src_addr), .src_rdata(src_rdata), .src_data(src_data)
    );
endmodule

// File: rtl/lut_xfer_seq_chk.sv
// Checker: temporal properties of the transfer sequencer, bound to the top.
module lut_xfer_seq_chk #(
    parameter int LUT_DEPTH = 512,
    parameter int RF_AW     = 9,
    parameter int DW        = 32,
    parameter int NUM_SRC   = 2,
    localparam int LUT_AW   = $clog2(LUT_DEPTH)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     done,
    input logic                     lut_we,
    input logic                     rf_we,
    input logic [RF_AW-1:0]         rf_waddr,
    input logic [DW-1:0]            rf_wdata,
    input logic [NUM_SRC*RF_AW-1:0] src_addr,
    input logic [NUM_SRC*DW-1:0]    src_data
);
    // R2: a read result appears after exactly two earlier busy cycles
    p_read_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ($past(busy) && $past(busy, 2) && !$past(busy, 3)));

    // R3: the store issues in the first busy cycle and done follows directly
    p_write_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |-> (!$past(busy) && !done));
    p_write_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |=> (done && !rf_we && !lut_we));

    // R5: lane 0 matching the write-back address sees the write-back data
    p_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && src_addr[RF_AW-1:0] == rf_waddr) |-> (src_data[DW-1:0] == rf_wdata));

    // R8: register-file write only in a final cycle
    p_rfwe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (done && busy));

    // R9: done is a one-cycle pulse that ends the busy period
    p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));
endmodule

bind lut_xfer_seq lut_xfer_seq_chk #(
    .LUT_DEPTH(LUT_DEPTH), .RF_AW(RF_AW), .DW(DW), .NUM_SRC(NUM_SRC)
) u_chk (.*);

// File: tb/lut_xfer_seq_test.sv
module lut_xfer_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LUT_AW = 9;
    localparam int RF_AW  = 9;
    localparam int DW     = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid, cmd_write;
    logic [LUT_AW-1:0] cmd_lut_addr;
    logic [RF_AW-1:0]  cmd_rf_addr;
    logic [DW-1:0]     cmd_wdata;
    logic              busy, done, lut_we, rf_we;
    logic [LUT_AW-1:0] lut_addr;
    logic [DW-1:0]     lut_wdata, rf_wdata;
    logic [RF_AW-1:0]  rf_waddr;
    logic [2*RF_AW-1:0] src_addr;
    logic [2*DW-1:0]   src_rdata, src_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [DW-1:0] model [512];
    bit written [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_lut_addr(cmd_lut_addr), .cmd_rf_addr(cmd_rf_addr), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
        .lut_we(lut_we), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .src_addr(src_addr), .src_rdata(src_rdata), .src_data(src_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fwd_exp(input logic [RF_AW-1:0] a, input bit live,
                                              input logic [RF_AW-1:0] dst, input logic [DW-1:0] held,
                                              input logic [DW-1:0] rf);
        return (live && a == dst) ? held : rf;
    endfunction

    // Drive a noise command while busy (R4).
    task automatic noise();
        cmd_valid    = 1'b1;
        cmd_write    = 1'($urandom);
        cmd_lut_addr = LUT_AW'($urandom);
        cmd_rf_addr  = RF_AW'($urandom);
        cmd_wdata    = $urandom;
    endtask

    task automatic do_write(input logic [LUT_AW-1:0] a, input logic [DW-1:0] d, input bit with_noise);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_lut_addr = a; cmd_wdata = d; cmd_rf_addr = '0;
        @(posedge clk); @(negedge clk);
        if (with_noise) noise(); else cmd_valid = 1'b0;
        chk(busy && !done, "R3 write issue busy", {busy, done}, 2'b10);
        chk(lut_we && lut_addr == a && lut_wdata == d, "R3 write issue port",
            {lut_we, lut_addr, lut_wdata}, {1'b1, a, d});
        @(negedge clk);
        chk(busy && done && !lut_we, "R3 write finish", {busy, done, lut_we}, 3'b110);
        chk(!rf_we, "R8 no rf write on store", rf_we, 0);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R9 R4 idle after write", {busy, done}, 0);
        model[a] = d; written[a] = 1'b1;
    endtask

    task automatic do_read(input logic [LUT_AW-1:0] a, input logic [RF_AW-1:0] dst, input bit with_noise);
        logic [DW-1:0] e;
        logic [DW-1:0] r0, r1;
        e = model[a];
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_lut_addr = a; cmd_rf_addr = dst;
        @(posedge clk); @(negedge clk);
        if (with_noise) noise(); else cmd_valid = 1'b0;
        chk(busy && !done && !rf_we && !lut_we, "R2 read issue", {busy, done, rf_we, lut_we}, 4'b1000);
        chk(lut_addr == a, "R2 read address", lut_addr, a);
        @(negedge clk);
        chk(busy && !done && !rf_we, "R2 read capture", {busy, done, rf_we}, 3'b100);
        @(negedge clk);
        chk(busy && done && rf_we, "R2 read finish", {busy, done, rf_we}, 3'b111);
        chk(rf_waddr == dst && rf_wdata == e, "R2 read result", {rf_waddr, rf_wdata}, {dst, e});
        r0 = $urandom; r1 = $urandom;
        src_addr = {RF_AW'(dst + 1), dst}; src_rdata = {r1, r0};
        #1;
        chk(src_data[DW-1:0] == fwd_exp(dst, 1, dst, e, r0), "R5 forward in finish cycle",
            src_data[DW-1:0], e);
        chk(src_data[2*DW-1:DW] == r1, "R6 pass-through lane", src_data[2*DW-1:DW], r1);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R9 R4 idle after read", {busy, done}, 0);
        r0 = $urandom; r1 = $urandom;
        src_addr = {dst, RF_AW'(dst ^ 9'h100)}; src_rdata = {r1, r0};
        #1;
        chk(src_data[2*DW-1:DW] == e, "R5 forward while held", src_data[2*DW-1:DW], e);
        chk(src_data[DW-1:0] == r0, "R6 no match", src_data[DW-1:0], r0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_lut_addr = '0;
        cmd_rf_addr = '0; cmd_wdata = '0; src_addr = '0; src_rdata = 64'h1234_5678_9abc_def0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && !done && !lut_we && !rf_we, "R1 reset outputs", {busy, done, lut_we, rf_we}, 0);
        chk(src_data == src_rdata, "R1 R6 reset pass-through", src_data, src_rdata);
        // Directed corners: end addresses, store then load same word (R7).
        do_write(9'd0, 32'hA5A5_0001, 0);
        do_write(9'd511, 32'hFFFF_FFFE, 0);
        do_read(9'd511, 9'd511, 0);
        do_write(9'd7, 32'h0BAD_F00D, 1);
        do_read(9'd7, 9'd3, 0);
        chk(rf_wdata == 32'h0BAD_F00D, "R7 load after store same word", rf_wdata, 32'h0BAD_F00D);
        do_read(9'd0, 9'd0, 1);
        // Random mix over a narrow address window.
        for (int i = 0; i < 400; i++) begin
            logic [LUT_AW-1:0] a;
            a = LUT_AW'($urandom_range(0, 15));
            if (!written[a] || ($urandom_range(0, 2) == 0))
                do_write(a, $urandom, 1'($urandom));
            else
                do_read(a, RF_AW'($urandom), 1'($urandom));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule